// File: doc/BRIEF.md
# GPIO Interrupt Status Latch with Separate Capture and Forward Enables

This block watches a bank of general-purpose input pins and turns pin activity into interrupt status. Every pin owns a small configuration word: a trigger mode (active-high level, active-low level, rising edge, falling edge or either edge), a capture enable and a forward enable. The capture enable decides whether a detected event may set the pin's sticky status bit. The forward enable decides whether a set status bit drives the single summary interrupt line. Software reads the configuration and status words through a simple register port, and clears status by writing ones.

Because the two enables are separate, software can handle a pin in two ways. For a level source, it clears capture while it services the pin, so that an acknowledge really empties the status bit. For an edge source, it clears only the forward enable, so that an edge arriving while the pin is masked is kept and is delivered once the pin is unmasked. Pin inputs are synchronised with two flops before detection.

Each pin's status is a two-state machine. `ST_CLEAR` moves to `ST_LATCHED` on a qualified event, meaning a trigger match while capture is enabled. `ST_LATCHED` moves back to `ST_CLEAR` on an acknowledge in a cycle with no qualified event. In every other case the state holds.

Top module: `gpio_irq_latch`

## Requirements
- R1: Trigger code field values: 0 means active while the synchronised input is 1, 1 means active while it is 0, 2 means a 0-to-1 change, 3 means a 1-to-0 change, 4 means either change, and codes 5 to 7 never detect anything.
- R2: While a pin's capture enable is 0, no trigger of any kind sets its status bit.
- R3: While a pin's forward enable is 0, its status bit can still set, but it does not drive `irq_summary`.
- R4: Writing 1 to a pin's bit at the status address clears that bit. A level pin whose input is still active and whose capture enable is 1 sets again at once, so one acknowledge cannot clear an asserted level.
- R5: An edge captured while the forward enable is 0 stays in status. Setting the forward enable then raises `irq_summary` one cycle after the write.
- R6: An edge pin acknowledged while masked stays clear until a new qualifying edge arrives.
- R7: One configuration write may change both enables of a pin, and both new values take effect on the same clock edge.
- R8: `irq_summary` is a register holding the OR over all pins of (status AND forward enable), one cycle late.
- R9: A pin input change reaches the status bit on the third rising clock edge after it is applied: two synchroniser flops, then the status register.
- R10: When a qualified event and an acknowledge hit the same pin in the same cycle, the status bit stays set.
- R11: Setting the capture enable creates no event by itself. Edge history updates every cycle whatever the enables, so a pin that was already high in rising mode stays clear when capture is turned on.
- R12: Register map, with pins numbered p = 0 to NUM_PINS-1. The configuration word of pin p is at address p, with trigger code in bits 2:0, capture enable in bit 3 and forward enable in bit 4. The status word is at address NUM_PINS, with bit p belonging to pin p. Any other address reads 0. Read data appears one cycle after `bus_rd`. After reset, all configuration, all status, `irq_summary` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_summary | output | 1 | Registered summary interrupt |

## Verification
Directed sequences cover the cases that separate the two enables:
- an asserted level that is acknowledged while still active, which must re-latch;
- an edge captured while masked and later unmasked, which must fire one cycle after the write;
- an edge acknowledged while masked, which must stay quiet until a fresh edge;
- capture turned on over a pin that is already high, which must not count as an edge;
- an event landing in the same cycle as its acknowledge.

A combined write of both enables is timed edge by edge, to show that both values took effect together. Seeded random traffic then mixes pin toggles, all eight trigger codes (the undefined ones included), enable writes, acknowledges and reads at every address. It checks each cycle against a cycle model in the bench, which catches slips in latency, priority and decoding.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W = 5;

    // Trigger codes; values 5..7 are undefined and detect nothing.
    typedef enum logic [2:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    // Packed MSB first: fwd_en is bit 4, latch_en bit 3, trig bits 2:0.
    typedef struct packed {
        logic       fwd_en;
        logic       latch_en;
        logic [2:0] trig;
    } pin_cfg_t;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_LATCHED = 1'b1
    } stat_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s,
    input  pin_cfg_t cfg,
    input  logic     ack,
    output logic     status,
    output logic     pending
);
    logic  pin_prev;
    logic  det;
    logic  hit;
    stat_e st_q, st_d;

    // Edge history runs regardless of enables, so enabling never fakes an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    always_comb begin
        case (cfg.trig)
            TRIG_LVL_HI: det = pin_s;
            TRIG_LVL_LO: det = ~pin_s;
            TRIG_RISE:   det = pin_s & ~pin_prev;
            TRIG_FALL:   det = ~pin_s & pin_prev;
            TRIG_BOTH:   det = pin_s ^ pin_prev;
            default:     det = 1'b0;
        endcase
        hit = det & cfg.latch_en;
    end

    // Next state: a qualified event beats an acknowledge.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAR:   if (hit) st_d = ST_LATCHED;
            ST_LATCHED: if (!hit && ack) st_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        status  = (st_q == ST_LATCHED);
        pending = status & cfg.fwd_en;
    end
endmodule

// File: rtl/gpio_summary.sv
module gpio_summary #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |pend;
    end
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch
    import gpio_irq_pkg::*;
#(
    parameter  int NUM_PINS = 8,
    parameter  int DATA_W   = 32,
    localparam int ADDR_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_summary
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

    pin_cfg_t            cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] status_vec;
    logic [NUM_PINS-1:0] pend_vec;
    logic [NUM_PINS-1:0] ack_vec;
    logic [NUM_PINS-1:0] raw_en_vec;
    logic [NUM_PINS-1:0] irq_en_vec;
    logic                stat_sel;
    logic [DATA_W-1:0]   rd_word;

    assign stat_sel = (bus_addr == STAT_ADDR);

    gpio_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    // Whole config word written at once: both enables change on one edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= '0;
        end else if (bus_wr) begin
            for (int p = 0; p < NUM_PINS; p++)
                if (bus_addr == ADDR_W'(p)) cfg_q[p] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign ack_vec[p]    = bus_wr & stat_sel & bus_wdata[p];
        assign raw_en_vec[p] = cfg_q[p].latch_en;
        assign irq_en_vec[p] = cfg_q[p].fwd_en;

        gpio_pin_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_sync[p]),
            .cfg     (cfg_q[p]),
            .ack     (ack_vec[p]),
            .status  (status_vec[p]),
            .pending (pend_vec[p])
        );
    end

    gpio_summary #(.W(NUM_PINS)) u_summary (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_vec),
        .irq   (irq_summary)
    );

    always_comb begin
        rd_word = '0;
        if (stat_sel) begin
            rd_word[NUM_PINS-1:0] = status_vec;
        end else begin
            for (int p = 0; p < NUM_PINS; p++)
                if (bus_addr == ADDR_W'(p)) rd_word[CFG_W-1:0] = cfg_q[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end
endmodule

// File: rtl/gpio_irq_latch_chk.sv
module gpio_irq_latch_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                irq_summary,
    input logic [NUM_PINS-1:0] status_vec,
    input logic [NUM_PINS-1:0] raw_en_vec,
    input logic [NUM_PINS-1:0] irq_en_vec
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R2: a status bit only rises if capture was enabled in the cycle before
        a_r2_latch_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_vec[i]) |-> $past(raw_en_vec[i]));

        // R4: a status bit only falls after a write-one acknowledge of that bit
        a_r4_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(status_vec[i]) |-> $past(bus_wr && (bus_addr == STAT_ADDR) && bus_wdata[i]));

        // R5: a set, forwarded bit raises the summary on the following edge
        a_r5_pending_forwards: assert property (@(posedge clk) disable iff (!rst_n)
            (status_vec[i] && irq_en_vec[i]) |=> irq_summary);
    end

    // R3: with every forward enable clear the summary stays low
    a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_vec == '0) |=> !irq_summary);
endmodule

bind gpio_irq_latch gpio_irq_latch_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .irq_summary (irq_summary),
    .status_vec  (status_vec),
    .raw_en_vec  (raw_en_vec),
    .irq_en_vec  (irq_en_vec)
);

// File: tb/gpio_irq_latch_bench.sv
`timescale 1ns/1ps
module gpio_irq_latch_bench;
    localparam int NP = 8;
    localparam int DW = 32;
    localparam int AW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_summary;

    always #2.5 clk = ~clk;

    gpio_irq_latch #(.NUM_PINS(NP), .DATA_W(DW)) u_gpio_irq_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_summary (irq_summary)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Cycle model built from the requirements
    logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0;
    logic [4:0]    m_cfg [NP];
    logic          m_irq = 1'b0;
    logic [DW-1:0] m_rd = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R1 trigger codes, gated by capture enable (R2)
    function automatic logic f_hit(input logic [4:0] c, input logic s, input logic p);
        if (!c[3]) return 1'b0;
        case (c[2:0])
            3'd0:    return s;
            3'd1:    return !s;
            3'd2:    return s && !p;
            3'd3:    return !s && p;
            3'd4:    return s ^ p;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step();
        logic [NP-1:0] ns;
        logic          nirq;
        logic [DW-1:0] nrd;
        logic          rd_now;
        nirq = 1'b0;
        for (int i = 0; i < NP; i++) if (m_stat[i] && m_cfg[i][4]) nirq = 1'b1;
        for (int i = 0; i < NP; i++) begin
            logic h, a;
            h = f_hit(m_cfg[i], m_s2[i], m_prev[i]);
            a = bus_wr && (bus_addr == AW'(NP)) && bus_wdata[i];
            ns[i] = h | (m_stat[i] & ~a);   // R10 set wins
        end
        nrd = m_rd;
        rd_now = bus_rd;
        if (bus_rd) begin
            nrd = '0;
            if (bus_addr == AW'(NP)) nrd[NP-1:0] = m_stat;
            else if (int'(bus_addr) < NP) nrd[4:0] = m_cfg[bus_addr];
        end
        if (bus_wr && int'(bus_addr) < NP) m_cfg[bus_addr] = bus_wdata[4:0];
        @(posedge clk);
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        m_stat = ns; m_irq = nirq; m_rd = nrd;
        @(negedge clk);
        check("R8 summary vs model", 32'(irq_summary), 32'(m_irq));
        if (rd_now) check("R12 readback vs model", bus_rdata, m_rd);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr_cfg(input int p, input logic [2:0] trig, input logic raw, input logic en);
        bus_addr = AW'(p);
        bus_wdata = {27'd0, en, raw, trig};
        bus_wr = 1'b1;
        step();
    endtask

    task automatic ack(input logic [NP-1:0] m);
        bus_addr = AW'(NP);
        bus_wdata = DW'(m);
        bus_wr = 1'b1;
        step();
    endtask

    task automatic rd_stat(output logic [NP-1:0] v);
        bus_addr = AW'(NP);
        bus_rd = 1'b1;
        step();
        v = bus_rdata[NP-1:0];
    endtask

    logic [NP-1:0] sv;

    initial begin
        for (int i = 0; i < NP; i++) m_cfg[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check("R12 reset irq", 32'(irq_summary), 32'd0);
        check("R12 reset rdata", bus_rdata, 32'd0);
        rd_stat(sv);
        check("R12 reset status", 32'(sv), 32'd0);

        // R1/R4/R9: active-high level on pin 0, re-latch while still active
        wr_cfg(0, 3'd0, 1'b1, 1'b1);
        pin_in[0] = 1'b1;
        idle(2);
        rd_stat(sv);
        check("R9 not yet latched after two edges", 32'(sv[0]), 32'd0);
        idle(1);
        rd_stat(sv);
        check("R1 level-high latched", 32'(sv[0]), 32'd1);
        check("R8 summary high", 32'(irq_summary), 32'd1);
        ack(8'h01);
        rd_stat(sv);
        check("R4 asserted level re-latches after ack", 32'(sv[0]), 32'd1);
        pin_in[0] = 1'b0;
        idle(3);
        ack(8'h01);
        rd_stat(sv);
        check("R4 ack clears released level", 32'(sv[0]), 32'd0);
        idle(1);
        check("R8 summary low after clear", 32'(irq_summary), 32'd0);

        // R3/R5: rising edge on pin 1 captured while masked, then unmasked
        wr_cfg(1, 3'd2, 1'b1, 1'b0);
        pin_in[1] = 1'b1;
        idle(4);
        rd_stat(sv);
        check("R3 masked edge still latched", 32'(sv[1]), 32'd1);
        check("R3 masked pin keeps summary low", 32'(irq_summary), 32'd0);
        wr_cfg(1, 3'd2, 1'b1, 1'b1);
        check("R5 summary not before one cycle", 32'(irq_summary), 32'd0);
        idle(1);
        check("R5 unmask forwards held edge", 32'(irq_summary), 32'd1);

        // R6: ack while masked, no refire while high, new edge re-latches
        wr_cfg(1, 3'd2, 1'b1, 1'b0);
        ack(8'h02);
        idle(5);
        rd_stat(sv);
        check("R6 stays clear without new edge", 32'(sv[1]), 32'd0);
        pin_in[1] = 1'b0;
        idle(3);
        pin_in[1] = 1'b1;
        idle(4);
        rd_stat(sv);
        check("R6 new edge latches", 32'(sv[1]), 32'd1);
        ack(8'h02);

        // R2: both-edge pin 2 with capture off
        wr_cfg(2, 3'd4, 1'b0, 1'b1);
        for (int k = 0; k < 6; k++) begin
            pin_in[2] = ~pin_in[2];
            idle(3);
        end
        rd_stat(sv);
        check("R2 capture off blocks edges", 32'(sv[2]), 32'd0);

        // R11: capture enabled over an already-high rising pin
        wr_cfg(3, 3'd2, 1'b0, 1'b1);
        pin_in[3] = 1'b1;
        idle(4);
        wr_cfg(3, 3'd2, 1'b1, 1'b1);
        idle(4);
        rd_stat(sv);
        check("R11 enabling capture is no edge", 32'(sv[3]), 32'd0);

        // R7: both enables set in one write on pin 4 with level high
        wr_cfg(4, 3'd0, 1'b0, 1'b0);
        pin_in[4] = 1'b1;
        idle(4);
        wr_cfg(4, 3'd0, 1'b1, 1'b1);
        idle(1);
        check("R7 summary waits for latch", 32'(irq_summary), 32'd0);
        idle(1);
        check("R7 both enables took effect together", 32'(irq_summary), 32'd1);
        wr_cfg(4, 3'd0, 1'b0, 1'b0);
        idle(1);
        check("R7 both cleared together drops summary", 32'(irq_summary), 32'd0);
        pin_in[4] = 1'b0;
        ack(8'h10);

        // R10: event and acknowledge in the same cycle on pin 5
        wr_cfg(5, 3'd2, 1'b1, 1'b0);
        pin_in[5] = 1'b1;
        idle(4);
        pin_in[5] = 1'b0;
        idle(4);
        pin_in[5] = 1'b1;
        idle(2);
        ack(8'h20);
        rd_stat(sv);
        check("R10 set beats ack", 32'(sv[5]), 32'd1);
        ack(8'h20);
        rd_stat(sv);
        check("R4 edge ack clears", 32'(sv[5]), 32'd0);

        // R1: active-low level on pin 6, undefined code on pin 7
        wr_cfg(6, 3'd1, 1'b1, 1'b0);
        wr_cfg(7, 3'd6, 1'b1, 1'b1);
        pin_in[7] = 1'b1;
        idle(4);
        pin_in[7] = 1'b0;
        idle(4);
        rd_stat(sv);
        check("R1 level-low latches at 0", 32'(sv[6]), 32'd1);
        check("R1 undefined code detects nothing", 32'(sv[7]), 32'd0);

        // Random traffic, all compared with the model (R1..R12)
        for (int k = 0; k < 6000; k++) begin
            int op;
            if ($urandom_range(0, 3) == 0) pin_in[$urandom_range(0, NP-1)] ^= 1'b1;
            op = $urandom_range(0, 9);
            if (op == 6) begin
                bus_addr = AW'($urandom_range(0, NP));
                bus_wdata = DW'($urandom_range(0, 31));
                bus_wr = 1'b1;
            end else if (op == 7) begin
                bus_addr = AW'(NP);
                bus_wdata = DW'($urandom_range(0, 255));
                bus_wr = 1'b1;
            end else if (op >= 8) begin
                bus_addr = AW'($urandom_range(0, (1 << AW) - 1));
                bus_rd = 1'b1;
            end
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule